// File: doc/BRIEF.md
# Four-Channel Wiper Position Bank

This block keeps the tap position of four digitally controlled resistor ladders. Each channel holds a 6-bit position. The block turns each position into a one-hot select across 64 tap switches, so exactly one switch on each ladder is closed. Position 0 closes the switch at the low terminal. Position 63 closes the switch at the high terminal.

A command decoder sits outside the block and drives single-cycle strobes into it. A position can change in four ways:

- a direct write of a value to one channel;
- a copy from one of the channel's four stored data registers, either for one channel or for all four channels together using a shared register index;
- a single step up or down, issued once for each serial clock high pulse while step mode is active;
- a boot load that copies data register 0 of every channel into its position.

The stored data registers reach the block as a flat input bus, and their nonvolatile timing is handled elsewhere. The positions are volatile. Nothing is written back to storage.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low, every position is 0 and every channel selects tap 0. The reset is asynchronous.
- R2: For channel c, `tap_sel[c*64 +: 64]` has exactly one bit set, and that bit is the one whose index equals the channel's position.
- R3: A `wr_stb` with `wr_chan`=c sets channel c to `wr_val` at that clock edge. Other channels are unchanged.
- R4: A `xfer_stb` with `xfer_all`=0 copies the data register `dreg_bus[(c*4+r)*6 +: 6]` into channel c = `xfer_chan`, where r = `xfer_reg`. Other channels are unchanged.
- R5: A `xfer_stb` with `xfer_all`=1 copies register `xfer_reg` of each channel into that same channel, for all four channels in one edge.
- R6: `boot_load` copies register 0 of every channel into its position and overrides every other request in that cycle.
- R7: A `step_stb` on channel `step_chan` raises the position by one when `step_up`=1 and lowers it by one when `step_up`=0. Only that channel moves.
- R8: Stepping saturates. An up step at 63 stays at 63, and a down step at 0 stays at 0.
- R9: On one channel in one cycle, the priority is boot load, then write, then transfer, then step. A load on one channel does not block a step on another channel.
- R10: A channel with no request in a cycle keeps its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_load | input | 1 | Load every channel from its data register 0 |
| wr_stb | input | 1 | Direct write strobe |
| wr_chan | input | 2 | Channel targeted by the write |
| wr_val | input | 6 | Value to write |
| xfer_stb | input | 1 | Data-register transfer strobe |
| xfer_all | input | 1 | 1: transfer to all channels; 0: only `xfer_chan` |
| xfer_chan | input | 2 | Channel for a single transfer |
| xfer_reg | input | 2 | Data register index to copy from |
| step_stb | input | 1 | One step request |
| step_chan | input | 2 | Channel to step |
| step_up | input | 1 | 1: toward the high end; 0: toward the low end |
| dreg_bus | input | 96 | Stored data registers, register r of channel c at bits (c*4+r)*6 |
| wiper_pos | output | 24 | Positions, channel c at bits c*6 |
| tap_sel | output | 256 | One-hot tap selects, channel c at bits c*64 |

## Verification
Two functions can land on the same channel in the same cycle: a parallel load (a write or a transfer) and a step. The bench provokes this by driving both strobes in the same cycle at the same channel, and again with a step aimed at a boot load. The result passes only if the loaded value appears after the edge, with no step applied on top of it. A paired case sends the load to one channel and the step to another in the same cycle. It expects both changes to take effect.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD  = 3'd0,
    SRC_BOOT  = 3'd1,
    SRC_WRITE = 3'd2,
    SRC_XFER  = 3'd3,
    SRC_STEP  = 3'd4
  } src_e;
endpackage

// File: rtl/tap_decode.sv
module tap_decode #(
  parameter int PW = 6
) (
  input  logic [PW-1:0]      pos,
  output logic [(1<<PW)-1:0] tap
);
  localparam int NTAP = 1 << PW;

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = (pos == PW'(k));
  end
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan
  import wiper_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_hit,
  input  logic [PW-1:0] boot_val,
  input  logic          wr_hit,
  input  logic [PW-1:0] wr_val,
  input  logic          xfer_hit,
  input  logic [PW-1:0] xfer_val,
  input  logic          step_hit,
  input  logic          step_up,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] POS_MAX = '1;

  function automatic logic [PW-1:0] step_sat(input logic [PW-1:0] cur, input logic up);
    if (up)
      return (cur == POS_MAX) ? cur : cur + 1'b1;
    else
      return (cur == '0) ? cur : cur - 1'b1;
  endfunction

  src_e          src;
  logic [PW-1:0] nxt;

  always_comb begin
    if (boot_hit)      src = SRC_BOOT;
    else if (wr_hit)   src = SRC_WRITE;
    else if (xfer_hit) src = SRC_XFER;
    else if (step_hit) src = SRC_STEP;
    else               src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_BOOT:  nxt = boot_val;
      SRC_WRITE: nxt = wr_val;
      SRC_XFER:  nxt = xfer_val;
      SRC_STEP:  nxt = step_sat(pos, step_up);
      default:   nxt = pos;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= nxt;
  end

  // R6
  boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_hit |=> pos == $past(boot_val));
  // R3
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !boot_hit) |=> pos == $past(wr_val));
  // R9
  xfer_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_hit && step_hit && !wr_hit && !boot_hit) |=> pos == $past(xfer_val));
  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_hit && step_up && !xfer_hit && !wr_hit && !boot_hit && pos != POS_MAX)
      |=> pos == $past(pos) + 1'b1);
  // R8
  ceil_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_hit && step_up && !xfer_hit && !wr_hit && !boot_hit && pos == POS_MAX)
      |=> pos == POS_MAX);
  // R8
  floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_hit && !step_up && !xfer_hit && !wr_hit && !boot_hit && pos == '0)
      |=> pos == '0);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_hit && !wr_hit && !xfer_hit && !step_hit) |=> $stable(pos));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int NCH  = 4,
  parameter int NREG = 4,
  parameter int PW   = 6,
  localparam int CHW  = (NCH  > 1) ? $clog2(NCH)  : 1,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NTAP = 1 << PW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boot_load,
  input  logic                   wr_stb,
  input  logic [CHW-1:0]         wr_chan,
  input  logic [PW-1:0]          wr_val,
  input  logic                   xfer_stb,
  input  logic                   xfer_all,
  input  logic [CHW-1:0]         xfer_chan,
  input  logic [RW-1:0]          xfer_reg,
  input  logic                   step_stb,
  input  logic [CHW-1:0]         step_chan,
  input  logic                   step_up,
  input  logic [NCH*NREG*PW-1:0] dreg_bus,
  output logic [NCH*PW-1:0]      wiper_pos,
  output logic [NCH*NTAP-1:0]    tap_sel
);
  logic [PW-1:0] dr [NCH][NREG];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign dr[c][r] = dreg_bus[(c*NREG + r)*PW +: PW];
    end

    logic          wr_hit, xfer_hit, step_hit;
    logic [PW-1:0] pos_c;

    assign wr_hit   = wr_stb   && (wr_chan   == CHW'(c));
    assign xfer_hit = xfer_stb && (xfer_all || (xfer_chan == CHW'(c)));
    assign step_hit = step_stb && (step_chan == CHW'(c));

    wiper_chan #(.PW(PW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_hit (boot_load),
      .boot_val (dr[c][0]),
      .wr_hit   (wr_hit),
      .wr_val   (wr_val),
      .xfer_hit (xfer_hit),
      .xfer_val (dr[c][xfer_reg]),
      .step_hit (step_hit),
      .step_up  (step_up),
      .pos      (pos_c)
    );

    tap_decode #(.PW(PW)) u_dec (
      .pos (pos_c),
      .tap (tap_sel[c*NTAP +: NTAP])
    );

    assign wiper_pos[c*PW +: PW] = pos_c;

    // R2
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[c*NTAP +: NTAP]) == 1);
    // R2
    tap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_sel[c*NTAP + int'(pos_c)]);
    // R5
    global_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && xfer_all && !wr_hit && !boot_load) |=> pos_c == $past(dr[c][xfer_reg]));
  end
endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          boot_load = 0, wr_stb = 0, xfer_stb = 0, xfer_all = 0, step_stb = 0, step_up = 0;
  logic [1:0]    wr_chan = 0, xfer_chan = 0, xfer_reg = 0, step_chan = 0;
  logic [5:0]    wr_val = 0;
  logic [95:0]   dreg_bus;
  logic [23:0]   wiper_pos;
  logic [255:0]  tap_sel;

  wiper_bank u_dut (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load),
    .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_val(wr_val),
    .xfer_stb(xfer_stb), .xfer_all(xfer_all), .xfer_chan(xfer_chan), .xfer_reg(xfer_reg),
    .step_stb(step_stb), .step_chan(step_chan), .step_up(step_up),
    .dreg_bus(dreg_bus), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  int n_chk = 0, n_bad = 0;
  int model [4];

  function automatic int dval(int c, int r);
    if (c == 0 && r == 1) return 62;
    if (c == 1 && r == 2) return 1;
    return (c*13 + r*7 + 9) % 64;
  endfunction

  initial begin
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        dreg_bus[(c*4+r)*6 +: 6] = 6'(dval(c, r));
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < 4; c++) begin
      chk(tag, 64'(wiper_pos[c*6 +: 6]), 64'(model[c]));
      chk("R2 tap", tap_sel[c*64 +: 64], 64'd1 << model[c]);
    end
  endtask

  task automatic drive(string tag, logic b, logic w, logic [1:0] wc, logic [5:0] wv,
                       logic x, logic xa, logic [1:0] xc, logic [1:0] xr,
                       logic s, logic [1:0] sc, logic su);
    @(negedge clk);
    boot_load = b; wr_stb = w; wr_chan = wc; wr_val = wv;
    xfer_stb = x; xfer_all = xa; xfer_chan = xc; xfer_reg = xr;
    step_stb = s; step_chan = sc; step_up = su;
    @(posedge clk); #1;
    boot_load = 0; wr_stb = 0; xfer_stb = 0; step_stb = 0;
    for (int c = 0; c < 4; c++) begin
      if (b)                               model[c] = dval(c, 0);
      else if (w && wc == c)               model[c] = int'(wv);
      else if (x && (xa || xc == c))       model[c] = dval(c, int'(xr));
      else if (s && sc == c) begin
        int t = model[c] + (su ? 1 : -1);
        model[c] = (t < 0) ? 0 : ((t > 63) ? 63 : t);
      end
    end
    check_all(tag);
  endtask

  // {op[3:0], ch[1:0], val[5:0]}; op 0 boot,1 write,2 xfer one,3 xfer all,4 up,5 down,6 idle
  localparam logic [11:0] VTAB [13] = '{
    {4'd0, 2'd0, 6'd0}, {4'd1, 2'd2, 6'd40}, {4'd2, 2'd0, 6'd1},
    {4'd4, 2'd0, 6'd0}, {4'd4, 2'd0, 6'd0}, {4'd2, 2'd1, 6'd2},
    {4'd5, 2'd1, 6'd0}, {4'd5, 2'd1, 6'd0}, {4'd3, 2'd0, 6'd3},
    {4'd5, 2'd3, 6'd0}, {4'd6, 2'd0, 6'd0}, {4'd1, 2'd3, 6'd0},
    {4'd4, 2'd3, 6'd0}
  };

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) model[c] = 0;
    #10;
    check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;

    foreach (VTAB[i]) begin
      logic [3:0] op = VTAB[i][11:8];
      logic [1:0] ch = VTAB[i][7:6];
      logic [5:0] v  = VTAB[i][5:0];
      case (op)
        4'd0: drive("R6 boot", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        4'd1: drive("R3 write", 0, 1, ch, v, 0, 0, 0, 0, 0, 0, 0);
        4'd2: drive("R4 xfer", 0, 0, 0, 0, 1, 0, ch, v[1:0], 0, 0, 0);
        4'd3: drive("R5 global", 0, 0, 0, 0, 1, 1, 0, v[1:0], 0, 0, 0);
        4'd4: drive("R7 R8 step up", 0, 0, 0, 0, 0, 0, 0, 0, 1, ch, 1);
        4'd5: drive("R7 R8 step down", 0, 0, 0, 0, 0, 0, 0, 0, 1, ch, 0);
        default: drive("R10 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      endcase
    end

    // R9: write beats step on same channel
    drive("R9 write>step", 0, 1, 2, 6'd17, 0, 0, 0, 0, 1, 2, 1);
    // R9: transfer beats step on same channel
    drive("R9 xfer>step", 0, 0, 0, 0, 1, 0, 1, 2'd3, 1, 1, 0);
    // R9: write beats transfer on same channel
    drive("R9 write>xfer", 0, 1, 0, 6'd5, 1, 0, 0, 2'd2, 0, 0, 0);
    // R6 R9: boot beats everything
    drive("R6 R9 boot>all", 1, 1, 3, 6'd33, 1, 1, 0, 2'd1, 1, 3, 1);
    // R9: load on ch0 and step on ch1 both happen
    drive("R9 split", 0, 1, 0, 6'd50, 0, 0, 0, 0, 1, 1, 1);
    // R8: saturation at top after direct write to 63
    drive("R3 write max", 0, 1, 2, 6'd63, 0, 0, 0, 0, 0, 0, 0);
    drive("R8 ceiling", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1);
    // R10: two idle cycles
    drive("R10 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    drive("R10 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    for (int c = 0; c < 4; c++) model[c] = 0;
    check_all("R1 async reset");
    @(negedge clk); rst_n = 1'b1;
    drive("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule